// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block watches the two divider outputs of a phase-locked loop: the divided reference and the divided feedback. All are sampled by one fast synchronous clock. For each phase-detector cycle it pairs a rising edge of one divider with the next rising edge of the other, whichever comes first. The distance between the two edges, counted in fast-clock ticks, is the phase error of that cycle.

An active-high lock flag has hysteresis. It is raised only after a run of consecutive cycles whose error stays under a tight set threshold. A precision-select input chooses between two set thresholds. Once raised, the flag stays high through moderate errors. It drops at once when one cycle shows an error above a much wider release limit, or when the partner edge never arrives. A power-down input clears the whole detector synchronously. The surrounding PLL control logic reads the flag as a lock indication.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset `lock_out` is 0.
- R2: With `precise_sel` = 0, `lock_out` rises only after `RUN_LEN` (default 5) consecutive cycles each with an error below `LOOSE_TICKS` (default 10). It stays 0 after four such cycles, and an error of exactly 9 ticks still counts as small.
- R3: With `precise_sel` = 1, the set threshold is `TIGHT_TICKS` (default 3). Errors of 3 or 5 ticks do not count toward lock.
- R4: A cycle whose error is at or above the selected set threshold restarts the consecutive-cycle run from zero.
- R5: While locked, a cycle with error greater than `UNLOCK_TICKS` (default 25) clears `lock_out`. Errors up to and including 25 ticks leave it high.
- R6: The error is the tick distance between the two rising edges in either order. Edges in the same sample give error 0, and an edge sampled d ticks after its partner gives error d.
- R7: If one edge is not followed by the other within `TIMEOUT_TICKS` (default 40) ticks, that cycle counts as a large error and clears `lock_out`.
- R8: While `pwr_down` is 1, `lock_out` is 0 from the next clock edge on, and edge pairs are ignored. After release, a full new run of `RUN_LEN` small cycles is needed to lock.
- R9: The run counter saturates, so `lock_out` stays high through an arbitrarily long series of small-error cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock; one tick of phase error |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Synchronous clear of the detector, held while high |
| precise_sel | input | 1 | 0 selects the loose set threshold, 1 the tight one |
| ref_div_in | input | 1 | Divided reference, synchronous to clk |
| fb_div_in | input | 1 | Divided feedback, synchronous to clk |
| lock_out | output | 1 | Active-high lock indication |

## Verification
One table of edge pairs drives the main function. It uses runs of small errors of different lengths, a run broken by an error right at the loose threshold, an error of exactly one tick under it, moderate errors inside the hysteresis band, and errors just at and beyond the release limit. The feedback-first and coincident-edge patterns separate a correct two-sided measurement from one that counts from the reference only. Tight-mode rows with 3- and 5-tick errors show which threshold is in force. Directed cases cover a missing partner edge, a long small-error run, and power-down with edge pairs that arrive while it is held.

// File: rtl/plm_pkg.sv
package plm_pkg;
   typedef enum logic {
      MTR_IDLE = 1'b0,
      MTR_WAIT = 1'b1
   } mtr_state_e;

   localparam int unsigned NUM_SRC = 2;
   localparam int unsigned SRC_REF = 0;
   localparam int unsigned SRC_FB  = 1;
endpackage

// File: rtl/plm_edge_det.sv
module plm_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sig_in;
   end

   assign rise_o = sig_in & ~prev_q;
endmodule

// File: rtl/plm_phase_meter.sv
module plm_phase_meter
   import plm_pkg::*;
#(
   parameter int unsigned TIMEOUT_TICKS = 40,
   localparam int unsigned ERR_W = $clog2(TIMEOUT_TICKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ref_rise,
   input  logic             fb_rise,
   output logic             meas_valid,
   output logic             meas_timeout,
   output logic [ERR_W-1:0] meas_err,
   output logic [ERR_W-1:0] wait_cnt
);
   localparam logic [ERR_W-1:0] TO_LIM = ERR_W'(TIMEOUT_TICKS);

   mtr_state_e       state_q;
   logic             first_ref_q;
   logic [ERR_W-1:0] cnt_q;
   logic             other_rise;
   logic             same_rise;

   assign other_rise = first_ref_q ? fb_rise  : ref_rise;
   assign same_rise  = first_ref_q ? ref_rise : fb_rise;
   assign wait_cnt   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= MTR_IDLE;
         first_ref_q  <= 1'b0;
         cnt_q        <= '0;
         meas_valid   <= 1'b0;
         meas_timeout <= 1'b0;
         meas_err     <= '0;
      end else if (clr) begin
         state_q      <= MTR_IDLE;
         cnt_q        <= '0;
         meas_valid   <= 1'b0;
         meas_timeout <= 1'b0;
      end else begin
         meas_valid <= 1'b0;
         unique case (state_q)
            MTR_IDLE: begin
               if (ref_rise && fb_rise) begin
                  meas_valid   <= 1'b1;
                  meas_timeout <= 1'b0;
                  meas_err     <= '0;
               end else if (ref_rise || fb_rise) begin
                  state_q     <= MTR_WAIT;
                  first_ref_q <= ref_rise;
                  cnt_q       <= ERR_W'(1);
               end
            end
            MTR_WAIT: begin
               if (other_rise) begin
                  meas_valid   <= 1'b1;
                  meas_timeout <= 1'b0;
                  meas_err     <= cnt_q;
                  cnt_q        <= '0;
                  state_q      <= MTR_IDLE;
               end else if (same_rise) begin
                  // partner missing: report a large error, restart from this edge
                  meas_valid   <= 1'b1;
                  meas_timeout <= 1'b1;
                  meas_err     <= cnt_q;
                  cnt_q        <= ERR_W'(1);
               end else if (cnt_q == TO_LIM) begin
                  meas_valid   <= 1'b1;
                  meas_timeout <= 1'b1;
                  meas_err     <= cnt_q;
                  cnt_q        <= '0;
                  state_q      <= MTR_IDLE;
               end else begin
                  cnt_q <= cnt_q + ERR_W'(1);
               end
            end
            default: state_q <= MTR_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/plm_lock_fsm.sv
module plm_lock_fsm #(
   parameter int unsigned TIGHT_TICKS   = 3,
   parameter int unsigned LOOSE_TICKS   = 10,
   parameter int unsigned UNLOCK_TICKS  = 25,
   parameter int unsigned TIMEOUT_TICKS = 40,
   parameter int unsigned RUN_LEN       = 5,
   localparam int unsigned ERR_W = $clog2(TIMEOUT_TICKS + 1),
   localparam int unsigned RUN_W = $clog2(RUN_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             precise_sel,
   input  logic             meas_valid,
   input  logic             meas_timeout,
   input  logic [ERR_W-1:0] meas_err,
   output logic [RUN_W-1:0] run_cnt,
   output logic             lock_q
);
   localparam logic [ERR_W-1:0] TIGHT_LIM  = ERR_W'(TIGHT_TICKS);
   localparam logic [ERR_W-1:0] LOOSE_LIM  = ERR_W'(LOOSE_TICKS);
   localparam logic [ERR_W-1:0] UNLOCK_LIM = ERR_W'(UNLOCK_TICKS);
   localparam logic [RUN_W-1:0] RUN_MAX    = RUN_W'(RUN_LEN);
   localparam logic [RUN_W-1:0] RUN_ARM    = RUN_W'(RUN_LEN - 1);

   logic [ERR_W-1:0] set_lim;
   logic             is_small;
   logic             is_big;

   assign set_lim  = precise_sel ? TIGHT_LIM : LOOSE_LIM;
   assign is_small = !meas_timeout && (meas_err < set_lim);
   assign is_big   = meas_timeout || (meas_err > UNLOCK_LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         lock_q  <= 1'b0;
      end else if (clr) begin
         run_cnt <= '0;
         lock_q  <= 1'b0;
      end else if (meas_valid) begin
         if (is_small) begin
            if (run_cnt != RUN_MAX) run_cnt <= run_cnt + RUN_W'(1);
            if (run_cnt >= RUN_ARM) lock_q <= 1'b1;
         end else begin
            run_cnt <= '0;
            if (is_big) lock_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
   import plm_pkg::*;
#(
   parameter int unsigned TIGHT_TICKS   = 3,
   parameter int unsigned LOOSE_TICKS   = 10,
   parameter int unsigned UNLOCK_TICKS  = 25,
   parameter int unsigned TIMEOUT_TICKS = 40,
   parameter int unsigned RUN_LEN       = 5,
   localparam int unsigned ERR_W = $clog2(TIMEOUT_TICKS + 1),
   localparam int unsigned RUN_W = $clog2(RUN_LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_down,
   input  logic precise_sel,
   input  logic ref_div_in,
   input  logic fb_div_in,
   output logic lock_out
);
   generate
      if (TIGHT_TICKS == 0 || TIGHT_TICKS > LOOSE_TICKS)
         $error("pll_lock_monitor: TIGHT_TICKS must be in 1..LOOSE_TICKS");
      if (LOOSE_TICKS > UNLOCK_TICKS)
         $error("pll_lock_monitor: LOOSE_TICKS must not exceed UNLOCK_TICKS");
      if (TIMEOUT_TICKS <= UNLOCK_TICKS)
         $error("pll_lock_monitor: TIMEOUT_TICKS must exceed UNLOCK_TICKS");
      if (RUN_LEN == 0)
         $error("pll_lock_monitor: RUN_LEN must be at least 1");
   endgenerate

   logic [NUM_SRC-1:0] div_in;
   logic [NUM_SRC-1:0] div_rise;
   logic               meas_valid;
   logic               meas_timeout;
   logic [ERR_W-1:0]   meas_err;
   logic [ERR_W-1:0]   wait_cnt;
   logic [RUN_W-1:0]   run_cnt;

   assign div_in[SRC_REF] = ref_div_in;
   assign div_in[SRC_FB]  = fb_div_in;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_edge
      plm_edge_det edge_i (
         .clk   (clk),
         .rst_n (rst_n),
         .sig_in(div_in[s]),
         .rise_o(div_rise[s])
      );
   end

   plm_phase_meter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) meter_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (pwr_down),
      .ref_rise    (div_rise[SRC_REF]),
      .fb_rise     (div_rise[SRC_FB]),
      .meas_valid  (meas_valid),
      .meas_timeout(meas_timeout),
      .meas_err    (meas_err),
      .wait_cnt    (wait_cnt)
   );

   plm_lock_fsm #(
      .TIGHT_TICKS  (TIGHT_TICKS),
      .LOOSE_TICKS  (LOOSE_TICKS),
      .UNLOCK_TICKS (UNLOCK_TICKS),
      .TIMEOUT_TICKS(TIMEOUT_TICKS),
      .RUN_LEN      (RUN_LEN)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (pwr_down),
      .precise_sel (precise_sel),
      .meas_valid  (meas_valid),
      .meas_timeout(meas_timeout),
      .meas_err    (meas_err),
      .run_cnt     (run_cnt),
      .lock_q      (lock_out)
   );
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
   parameter int unsigned TIGHT_TICKS   = 3,
   parameter int unsigned LOOSE_TICKS   = 10,
   parameter int unsigned UNLOCK_TICKS  = 25,
   parameter int unsigned TIMEOUT_TICKS = 40,
   parameter int unsigned RUN_LEN       = 5,
   localparam int unsigned ERR_W = $clog2(TIMEOUT_TICKS + 1),
   localparam int unsigned RUN_W = $clog2(RUN_LEN + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_down,
   input logic             precise_sel,
   input logic             lock_out,
   input logic             meas_valid,
   input logic             meas_timeout,
   input logic [ERR_W-1:0] meas_err,
   input logic [ERR_W-1:0] wait_cnt,
   input logic [RUN_W-1:0] run_cnt
);
   always_comb begin
      if (!rst_n) assert_reset_clear_R1: assert (lock_out == 1'b0 || $isunknown(lock_out));
   end

   assert_rise_small_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_out) |-> ($past(meas_valid) && !$past(meas_timeout) &&
         (int'($past(meas_err)) < ($past(precise_sel) ? int'(TIGHT_TICKS) : int'(LOOSE_TICKS)))));

   assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!meas_valid && !pwr_down) |=> $stable(lock_out));

   assert_big_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && !pwr_down && (int'(meas_err) > int'(UNLOCK_TICKS))) |=> !lock_out);

   assert_timeout_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && meas_timeout) |=> !lock_out);

   assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wait_cnt) <= int'(TIMEOUT_TICKS));

   assert_pwrdn_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> (!lock_out && run_cnt == '0));

   assert_run_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(run_cnt) <= int'(RUN_LEN));
endmodule

bind pll_lock_monitor plm_checker #(
   .TIGHT_TICKS  (TIGHT_TICKS),
   .LOOSE_TICKS  (LOOSE_TICKS),
   .UNLOCK_TICKS (UNLOCK_TICKS),
   .TIMEOUT_TICKS(TIMEOUT_TICKS),
   .RUN_LEN      (RUN_LEN)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_down    (pwr_down),
   .precise_sel (precise_sel),
   .lock_out    (lock_out),
   .meas_valid  (meas_valid),
   .meas_timeout(meas_timeout),
   .meas_err    (meas_err),
   .wait_cnt    (wait_cnt),
   .run_cnt     (run_cnt)
);

// File: tb/pll_lock_monitor_tb_top.sv
module pll_lock_monitor_tb_top;
   localparam int TIMEOUT = 40;
   localparam int NVEC    = 34;

   typedef struct packed {
      logic signed [7:0] off;   // >0: feedback lags, <0: feedback leads
      logic              prec;
      logic              exp_lock;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      // R2 / R4: four small, then exactly-at-threshold restart
      '{8'sd2, 1'b0, 1'b0}, '{8'sd2, 1'b0, 1'b0}, '{8'sd2, 1'b0, 1'b0}, '{8'sd2, 1'b0, 1'b0},
      '{8'sd10, 1'b0, 1'b0},
      '{8'sd2, 1'b0, 1'b0}, '{8'sd2, 1'b0, 1'b0}, '{8'sd2, 1'b0, 1'b0}, '{8'sd2, 1'b0, 1'b0},
      '{8'sd2, 1'b0, 1'b1},
      // R5: hysteresis band holds, above release clears
      '{8'sd15, 1'b0, 1'b1}, '{8'sd26, 1'b0, 1'b0},
      // R6: feedback first, then 9 ticks still small
      '{-8'sd4, 1'b0, 1'b0}, '{-8'sd4, 1'b0, 1'b0}, '{-8'sd4, 1'b0, 1'b0}, '{-8'sd4, 1'b0, 1'b0},
      '{8'sd9, 1'b0, 1'b1},
      '{8'sd25, 1'b0, 1'b1}, '{8'sd30, 1'b0, 1'b0},
      // R3: tight threshold
      '{8'sd5, 1'b1, 1'b0}, '{8'sd5, 1'b1, 1'b0}, '{8'sd5, 1'b1, 1'b0}, '{8'sd5, 1'b1, 1'b0},
      '{8'sd5, 1'b1, 1'b0},
      '{8'sd2, 1'b1, 1'b0}, '{8'sd2, 1'b1, 1'b0}, '{8'sd2, 1'b1, 1'b0}, '{8'sd2, 1'b1, 1'b0},
      '{8'sd3, 1'b1, 1'b0},
      '{8'sd0, 1'b1, 1'b0}, '{8'sd1, 1'b1, 1'b0}, '{-8'sd2, 1'b1, 1'b0}, '{8'sd1, 1'b1, 1'b0},
      '{8'sd2, 1'b1, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_down = 1'b0;
   logic precise_sel = 1'b0;
   logic ref_div_in = 1'b0;
   logic fb_div_in = 1'b0;
   logic lock_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pll_lock_monitor #(.TIMEOUT_TICKS(TIMEOUT)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_down   (pwr_down),
      .precise_sel(precise_sel),
      .ref_div_in (ref_div_in),
      .fb_div_in  (fb_div_in),
      .lock_out   (lock_out)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: lock_out=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pd_pair(input int off);
      int d;
      d = (off < 0) ? -off : off;
      @(negedge clk);
      if (off >= 0) ref_div_in = 1'b1;
      if (off <= 0) fb_div_in  = 1'b1;
      repeat (d) @(negedge clk);
      ref_div_in = 1'b1;
      fb_div_in  = 1'b1;
      repeat (3) @(negedge clk);
      ref_div_in = 1'b0;
      fb_div_in  = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 during reset", lock_out, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 after reset", lock_out, 1'b0);

      // table walk: R2 R3 R4 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         precise_sel = VECS[i].prec;
         pd_pair(int'(VECS[i].off));
         checks++;
         if (lock_out !== VECS[i].exp_lock) begin
            errors++;
            $display("FAIL R2-table row %0d (R3/R4/R5/R6 path) off=%0d prec=%b: lock_out=%b expected=%b",
                     i, int'(VECS[i].off), VECS[i].prec, lock_out, VECS[i].exp_lock);
         end
      end

      // R9: long run of small cycles keeps lock
      for (int i = 0; i < 12; i++) begin
         pd_pair(1);
         check("R9 saturated run", lock_out, 1'b1);
      end

      // R7: reference edge with no feedback edge
      @(negedge clk);
      ref_div_in = 1'b1;
      repeat (TIMEOUT + 8) @(negedge clk);
      check("R7 timeout clears", lock_out, 1'b0);
      ref_div_in = 1'b0;
      repeat (5) @(negedge clk);

      // R8: power-down
      for (int i = 0; i < 5; i++) pd_pair(1);
      check("R8 relock before power-down", lock_out, 1'b1);
      @(negedge clk);
      pwr_down = 1'b1;
      @(negedge clk);
      check("R8 power-down clears", lock_out, 1'b0);
      for (int i = 0; i < 5; i++) pd_pair(0);
      check("R8 pairs ignored in power-down", lock_out, 1'b0);
      pwr_down = 1'b0;
      for (int i = 0; i < 4; i++) pd_pair(1);
      check("R8 four after release", lock_out, 1'b0);
      pd_pair(1);
      check("R8 fifth after release", lock_out, 1'b1);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule